// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner with Strobe

This block drives a five-digit time-multiplexed display and a data-transfer interface from a finished BCD reading. One digit at a time has its enable line high. A shared 4-bit BCD bus carries the value of whichever digit is enabled. The scan goes from the most significant digit to the least significant digit and then starts over, without stopping. The digit is selected by a slot counter and a per-digit cycle counter.

When a measurement-complete pulse arrives, the block captures the whole reading into a shadow register and restarts the scan at the leading digit. That leading digit is held one clock longer than normal. The block then sends exactly five active-low strobes, one in the middle of each digit in scan order. External latches, a processor or a UART can capture each digit on its strobe. Each strobe lasts half a clock period and is built from a rising-edge term and a falling-edge term, so no clock signal passes into the output path.

An overrange flag comes in with the measurement. If it is set, all digit enables are blanked once the strobe sequence ends, and they stay blanked until a de-integrate-start pulse arrives. The scan then restarts at the leading digit, which makes the display blink while the overrange condition lasts.

Top module: `digit_scanner`

## Requirements
- R1: While reset is held and after reset, until the first measurement-complete pulse: digit_en is 5'b10000 (bit 4 is the most significant digit), bcd is 0 and strobe_n stays high. No strobe is sent until the first measurement-complete pulse.
- R2: At most one digit enable is high at any time. The scan goes through digit_en[4], [3], [2], [1], [0] and then wraps back to digit_en[4].
- R3: Each digit enable stays high for 200 cycles. The first digit_en[4] period that starts on the cycle after a measurement-complete pulse is sampled lasts 201 cycles.
- R4: bcd shows the nibble of the captured reading for the active digit: reading[19:16] for digit_en[4], down to reading[3:0] for digit_en[0]. bcd changes in the same cycle as digit_en. A new reading is captured only on a measurement-complete pulse; changes on the reading input at other times have no effect.
- R5: A strobe is a low level on strobe_n. It starts at the falling clock edge of the cycle in which the active digit's cycle count equals 100 (the first cycle of a digit is count 0), and it ends at the next rising edge.
- R6: After each measurement-complete pulse, exactly five strobes are sent, one per digit from digit_en[4] to digit_en[0]. Scanning continues after that with no further strobes.
- R7: If overrange was high with the measurement-complete pulse, all digit enables go low and bcd reads 0 once the digit_en[0] period that carried the fifth strobe has ended. This lasts until a de-integrate-start pulse is sampled. The scan then restarts on the next cycle with a 200-cycle digit_en[4] period.
- R8: A de-integrate-start pulse has no effect while the display is not blanked.
- R9: A measurement-complete pulse that arrives in the middle of a scan or a strobe sequence restarts the 201-cycle leading digit and the five-strobe sequence, using the newly captured reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| meas_done | input | 1 | One-cycle pulse marking a completed measurement |
| reading | input | 20 | Five BCD nibbles, most significant digit in bits 19:16 |
| ovr_in | input | 1 | Overrange flag, sampled together with meas_done |
| deint_start | input | 1 | One-cycle pulse marking the start of de-integration |
| digit_en | output | 5 | One-hot digit enables, bit 4 is the most significant digit |
| bcd | output | 4 | BCD value of the active digit |
| strobe_n | output | 1 | Half-cycle active-low data strobe |

## Verification
The scanner is first run free with no measurement, to show that it scans but sends no strobes. Next comes an in-range reading whose input bus is changed after capture, with de-integrate pulses sent in the middle of the scan. This separates the captured reading from the live bus and shows that de-integrate-start is ignored outside blanking. A second measurement arrives in the middle of a strobe sequence, which shows whether the leading-digit stretch and the strobe count restart. Last, an overrange reading shows the blanking window and the restart on de-integrate-start, as against a plain continued scan.

// File: rtl/ds_pkg.sv
package ds_pkg;
  parameter int NDIG = 5;
  localparam int WORD_W = 4 * NDIG;
  localparam int SLOT_W = $clog2(NDIG);

  // cycles spent on one digit; the leading digit of a fresh reading gets one extra
  function automatic int unsigned span_of(input logic lead, input int unsigned w);
    return lead ? w + 1 : w;
  endfunction

  // slot 0 is the most significant nibble
  function automatic logic [3:0] pick_nibble(input logic [WORD_W-1:0] word,
                                             input logic [SLOT_W-1:0] slot);
    return word[(NDIG - 1 - int'(slot)) * 4 +: 4];
  endfunction
endpackage

// File: rtl/ds_timer.sv
module ds_timer import ds_pkg::*; #(
  parameter int unsigned W = 200,
  localparam int CNT_W = $clog2(W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              meas_done,
  input  logic              ovr_in,
  input  logic              deint_start,
  input  logic              drained,
  output logic [SLOT_W-1:0] slot,
  output logic [CNT_W-1:0]  cnt,
  output logic              blank,
  output logic              at_mid
);
  logic lead, arm;

  wire last_cyc     = (cnt == CNT_W'(span_of(lead, W) - 1));
  wire wrap_evt     = last_cyc && (slot == SLOT_W'(NDIG - 1));
  wire blank_on_evt = !meas_done && !blank && wrap_evt && arm && drained;
  assign at_mid = !blank && (cnt == CNT_W'(W / 2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; slot <= '0; lead <= 1'b0; blank <= 1'b0; arm <= 1'b0;
    end else if (meas_done) begin
      cnt <= '0; slot <= '0; lead <= 1'b1; blank <= 1'b0; arm <= ovr_in;
    end else if (blank) begin
      if (deint_start) blank <= 1'b0;
    end else if (last_cyc) begin
      cnt  <= '0;
      lead <= 1'b0;
      if (wrap_evt) begin
        slot <= '0;
        if (blank_on_evt) begin
          blank <= 1'b1;
          arm   <= 1'b0;
        end
      end else begin
        slot <= slot + 1'b1;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!meas_done && !blank && last_cyc && !wrap_evt) |=> slot == $past(slot) + 1'b1);

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(W));

  p_blank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (blank && !deint_start && !meas_done) |=> (blank && cnt == '0 && slot == '0));
endmodule

// File: rtl/ds_strobe.sv
module ds_strobe import ds_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic meas_done,
  input  logic at_mid,
  output logic drained,
  output logic strobe_n
);
  localparam int LEFT_W = $clog2(NDIG + 1);
  logic [LEFT_W-1:0] left;
  logic stb_neg;

  wire stb_req = at_mid && (left != '0);
  assign drained = (left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         left <= '0;
    else if (meas_done) left <= LEFT_W'(NDIG);
    else if (stb_req)   left <= left - 1'b1;
  end

  // falling-edge copy; AND with the rising-edge term gives the low clock half only
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) stb_neg <= 1'b0;
    else        stb_neg <= stb_req;
  end

  assign strobe_n = !(stb_req && stb_neg);

  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done |=> left == LEFT_W'(NDIG));

  p_left_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_req && !meas_done) |=> left == $past(left) - 1'b1);
endmodule

// File: rtl/digit_scanner.sv
module digit_scanner import ds_pkg::*; #(
  parameter int unsigned W = 200,
  localparam int CNT_W = $clog2(W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              meas_done,
  input  logic [WORD_W-1:0] reading,
  input  logic              ovr_in,
  input  logic              deint_start,
  output logic [NDIG-1:0]   digit_en,
  output logic [3:0]        bcd,
  output logic              strobe_n
);
  logic [WORD_W-1:0] shadow;
  logic [SLOT_W-1:0] slot;
  logic [CNT_W-1:0]  cnt;
  logic blank, at_mid, drained;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shadow <= '0;
    else if (meas_done) shadow <= reading;
  end

  ds_timer #(.W(W)) u_timer (
    .clk(clk), .rst_n(rst_n), .meas_done(meas_done), .ovr_in(ovr_in),
    .deint_start(deint_start), .drained(drained),
    .slot(slot), .cnt(cnt), .blank(blank), .at_mid(at_mid));

  ds_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .meas_done(meas_done), .at_mid(at_mid),
    .drained(drained), .strobe_n(strobe_n));

  for (genvar g = 0; g < NDIG; g++) begin : g_en
    assign digit_en[NDIG-1-g] = !blank && (slot == SLOT_W'(g));
  end

  assign bcd = blank ? 4'd0 : pick_nibble(shadow, slot);

  p_shadow_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_done |=> $stable(shadow));

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(digit_en));
endmodule

// File: tb/sim_digit_scanner.sv
module sim_digit_scanner;
  logic clk = 1'b0, rst_n = 1'b0, meas_done = 1'b0, ovr_in = 1'b0, deint_start = 1'b0;
  logic [19:0] reading = '0;
  logic [4:0] digit_en;
  logic [3:0] bcd;
  logic strobe_n;
  int checks = 0, fails = 0;

  typedef struct { logic [4:0] en; logic [3:0] val; } item_t;
  item_t sb[$];

  // reference state, built from the requirements
  int m_slot = 0, m_cnt = 0, m_left = 0;
  bit m_lead = 0, m_blank = 0, m_arm = 0;
  logic [19:0] m_word = '0;

  always #4 clk = ~clk;

  digit_scanner u0 (.clk(clk), .rst_n(rst_n), .meas_done(meas_done), .reading(reading),
    .ovr_in(ovr_in), .deint_start(deint_start), .digit_en(digit_en), .bcd(bcd),
    .strobe_n(strobe_n));

  task automatic check(input bit ok, input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] exp_en();
    return m_blank ? 5'd0 : 5'b10000 >> m_slot;
  endfunction
  function automatic logic [3:0] exp_bcd();
    return m_blank ? 4'd0 : m_word[(4 - m_slot) * 4 +: 4];
  endfunction
  function automatic bit exp_stb();
    return !m_blank && m_left != 0 && m_cnt == 100;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_slot = 0; m_cnt = 0; m_left = 0; m_lead = 0; m_blank = 0; m_arm = 0; m_word = '0;
    end else if (meas_done) begin
      m_slot = 0; m_cnt = 0; m_lead = 1; m_blank = 0; m_arm = ovr_in; m_left = 5; m_word = reading;
    end else begin
      bit drained_now;
      drained_now = (m_left == 0);
      if (exp_stb()) m_left--;
      if (m_blank) begin
        if (deint_start) m_blank = 0;
      end else if (m_cnt == (m_lead ? 200 : 199)) begin
        m_cnt = 0; m_lead = 0;
        if (m_slot == 4) begin
          m_slot = 0;
          if (m_arm && drained_now) begin m_blank = 1; m_arm = 0; end
        end else m_slot++;
      end else m_cnt++;
    end
  end

  // monitor: early sample for enables/bus, late sample (clock low) for the strobe
  always @(posedge clk) begin
    bit want;
    #2;
    if (rst_n) begin
      check(digit_en == exp_en(), "R2/R3/R7 digit_en", 20'(digit_en), 20'(exp_en()));
      check(bcd == exp_bcd(), "R4 bcd", 20'(bcd), 20'(exp_bcd()));
      check(strobe_n === 1'b1, "R5 strobe high in first half", 20'(strobe_n), 20'd1);
    end
    want = exp_stb();
    #4;
    if (rst_n) begin
      check(strobe_n === !want, "R5 strobe timing", 20'(strobe_n), 20'(!want));
      if (strobe_n === 1'b0) begin
        if (sb.size() == 0) check(0, "R6 extra strobe", 20'(digit_en), 20'd0);
        else begin
          item_t it;
          it = sb.pop_front();
          check(digit_en == it.en, "R6 strobe digit order", 20'(digit_en), 20'(it.en));
          check(bcd == it.val, "R4 strobed value", 20'(bcd), 20'(it.val));
        end
      end
    end
  end

  task automatic measure(input logic [19:0] w, input bit ovr);
    sb.delete();
    for (int i = 0; i < 5; i++) begin
      item_t it;
      it.en = 5'b10000 >> i;
      it.val = w[(4 - i) * 4 +: 4];
      sb.push_back(it);
    end
    @(posedge clk); #1;
    reading = w; ovr_in = ovr; meas_done = 1'b1;
    @(posedge clk); #1;
    meas_done = 1'b0; ovr_in = 1'b0;
  endtask

  task automatic pulse_deint();
    @(posedge clk); #1 deint_start = 1'b1;
    @(posedge clk); #1 deint_start = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    check(0, "watchdog", 20'd0, 20'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(digit_en == 5'b10000, "R1 reset digit_en", 20'(digit_en), 20'h10);
    check(bcd == 4'd0, "R1 reset bcd", 20'(bcd), 20'd0);
    check(strobe_n === 1'b1, "R1 reset strobe", 20'(strobe_n), 20'd1);
    #1 rst_n = 1'b1;
    idle(1100);                                   // R1: free scan, no strobes
    check(sb.size() == 0, "R1 no pending", 20'(sb.size()), 20'd0);

    measure(20'h12345, 1'b0);
    reading = 20'h99999;                          // R4: ignored until next capture
    idle(450);
    pulse_deint();                                // R8: ignored when not blanked
    idle(1200);
    check(sb.size() == 0, "R6 five strobes seen", 20'(sb.size()), 20'd0);

    measure(20'h98760, 1'b0);
    idle(250);
    measure(20'h24680, 1'b0);                     // R9: restart mid sequence
    idle(1300);
    check(sb.size() == 0, "R9 restarted sequence complete", 20'(sb.size()), 20'd0);

    measure(20'h19999, 1'b1);                     // R7: overrange blanking
    idle(1500);
    #2 check(digit_en == 5'd0, "R7 blanked", 20'(digit_en), 20'd0);
    pulse_deint();
    #2 check(digit_en == 5'b10000, "R7 restart at lead digit", 20'(digit_en), 20'h10);
    idle(1100);
    check(sb.size() == 0, "R6 overrange strobes complete", 20'(sb.size()), 20'd0);
    finish_run();
  end
endmodule